// File: doc/BRIEF.md
# Instruction Address Breakpoint Matcher

This block holds a bank of breakpoint pairs, each made of a 32-bit value word and a 32-bit control word. Software loads them over a small register port. On every cycle with a valid instruction fetch, each enabled pair is compared with the fetch address, the fetch size, the processor mode and the current context ID. One cycle later the block reports a breakpoint event and a vector showing which pairs hit.

A pair can do one of four things. It can match an address, with a choice of byte lanes and an optional mask on the low address bits. It can hit on every address that such a match would miss. It can match the whole value word against the context ID. It can match an address only while a second, context-matching pair also agrees. A mode filter in each pair decides in which processor modes it may hit.

Top module: `ibrk_bank`

## Requirements
- R1: After reset every pair is disabled, every value and control word reads 0, and `bp_event` and `bp_hits` are 0.
- R2: A write with `reg_ctl`=0 stores the whole value word of pair `reg_idx`, and with `reg_ctl`=1 the control word. Combinational reads return what was stored, except that control bits [4:3] always read 0.
- R3: Address pairs compare fetch address bits [31:2] with the value word. A nonzero mask M in control bits [28:24] removes address bits [M-1:0] from the compare.
- R4: Control bits [8:5] select byte lanes 3..0. A word fetch (`fetch_word`=1) touches all four lanes. A halfword fetch touches lanes 1:0 when `fetch_addr[1]`=0 and lanes 3:2 when it is 1. An address hit needs a selected lane that is also touched, so select 0000 never hits.
- R5: Kind 100 in control bits [22:20] is an inverted address pair. It hits exactly when the same pair set to kind 000 would miss, so with select 0000 it hits every fetch.
- R6: Control bits [2:1] filter on `fetch_mode`, where 00 is user, 01 supervisor, 10 system and 11 another privileged mode. Filter 00 passes user, supervisor and system. Filter 01 passes any mode except user. Filter 10 passes user only. Filter 11 passes all modes.
- R7: Kind 010 compares all 32 value bits with `fetch_ctx` and ignores the address, the size and the byte select.
- R8: Kind 001 needs three things together. The pair's own address and mode must match. The pair whose index is in control bits [19:16] must be enabled, must be of kind 010 and must match the context ID. If that index is not below the number of pairs, the pair never hits.
- R9: A pair hits only while control bit 0 is 1. Kinds 011, 101, 110 and 111 never hit.
- R10: `bp_event` and `bp_hits` are registered. After a clock edge that sampled `fetch_valid`=1, they show the result of that fetch. After an edge that sampled `fetch_valid`=0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ctl | input | 1 | Selects the word: 0 is the value word, 1 is the control word |
| reg_idx | input | IDX_W | Pair index for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| fetch_valid | input | 1 | A fetch is present this cycle |
| fetch_addr | input | 32 | Fetch address; bit 1 picks the halfword |
| fetch_word | input | 1 | 1 for a word fetch, 0 for a halfword fetch |
| fetch_mode | input | 2 | Current processor mode |
| fetch_ctx | input | 32 | Current context ID |
| bp_event | output | 1 | Registered breakpoint event |
| bp_hits | output | NUM_PAIRS | Registered per-pair hit vector |

## Verification
The assertions take the fetch inputs and the register port as valid at every rising edge. They also assume that reset is held long enough for the registered outputs to clear. The bench changes every input on the falling edge and never writes a register in the same cycle as a fetch it checks, so each result depends only on settled configuration. The link and context checks also assume that software sets byte select 1111 on a masked pair, and the bench keeps to that whenever it uses a mask.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

  typedef enum logic [2:0] {
    KIND_ADDR        = 3'b000,
    KIND_ADDR_LINKED = 3'b001,
    KIND_CTX         = 3'b010,
    KIND_ADDR_INV    = 3'b100
  } kind_e;

  // Control word layout; field positions are decoded by the comparators.
  typedef struct packed {
    logic [2:0] rsvd_hi;   // 31:29
    logic [4:0] mask;      // 28:24
    logic       rsvd23;    // 23
    logic [2:0] kind;      // 22:20
    logic [3:0] link;      // 19:16
    logic [6:0] rsvd_mid;  // 15:9
    logic [3:0] bas;       // 8:5
    logic [1:0] rsvd_lo;   // 4:3, read as zero
    logic [1:0] mode_sel;  // 2:1
    logic       en;        // 0
  } bctl_t;

  localparam logic [31:0] CTL_RAZ_BITS = 32'h0000_0018;

  // Byte lanes touched by a fetch of the given size at the given halfword.
  function automatic logic [3:0] fetch_lanes(input logic word, input logic half_hi);
    if (word) return 4'b1111;
    return half_hi ? 4'b1100 : 4'b0011;
  endfunction

  // Address bits taking part in the compare for a given mask width.
  function automatic logic [31:0] care_mask(input logic [4:0] m);
    logic [31:0] low;
    low = (32'd1 << m) - 32'd1;
    return ~low & 32'hFFFF_FFFC;
  endfunction

  // Mode filter: modes are 00 user, 01 supervisor, 10 system, 11 other privileged.
  function automatic logic mode_pass(input logic [1:0] sel, input logic [1:0] cur);
    case (sel)
      2'b00:   return cur != 2'b11;
      2'b01:   return cur != 2'b00;
      2'b10:   return cur == 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] ctl_scrub(input logic [31:0] w);
    return w & ~CTL_RAZ_BITS;
  endfunction

endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
  import ibrk_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_ctl,
  input  logic [IDX_W-1:0]                idx,
  input  logic [31:0]                     wdata,
  output logic [31:0]                     rdata,
  output logic [NUM_PAIRS-1:0][31:0]      val_o,
  output bctl_t [NUM_PAIRS-1:0]           ctl_o
);

  logic [NUM_PAIRS-1:0][31:0] val_q;
  bctl_t [NUM_PAIRS-1:0]      ctl_q;
  logic                       idx_ok;

  assign idx_ok = 32'(idx) < NUM_PAIRS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        val_q[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else if (wr_en && idx_ok) begin
      if (wr_ctl) ctl_q[idx] <= bctl_t'(ctl_scrub(wdata));
      else        val_q[idx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx_ok) rdata = wr_ctl ? 32'(ctl_q[idx]) : val_q[idx];
  end

  assign val_o = val_q;
  assign ctl_o = ctl_q;

  a_r2_reserved_raz: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |-> (rdata[4:3] == 2'b00));

endmodule

// File: rtl/ibrk_cmp.sv
module ibrk_cmp
  import ibrk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] val,
  input  bctl_t       ctl,
  input  logic [31:0] f_addr,
  input  logic        f_word,
  input  logic [1:0]  f_mode,
  input  logic [31:0] f_ctx,
  input  logic        link_ctx_ok,
  output logic        hit,
  output logic        ctx_ok
);

  logic addr_eq, lane_hit, addr_match, mode_ok, ctx_eq, raw;
  logic unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl.rsvd_hi, ctl.rsvd23, ctl.rsvd_mid, ctl.rsvd_lo, ctl.link};

  always_comb begin
    addr_eq    = ((f_addr ^ val) & care_mask(ctl.mask)) == 32'd0;
    lane_hit   = |(ctl.bas & fetch_lanes(f_word, f_addr[1]));
    addr_match = addr_eq && lane_hit;
    mode_ok    = mode_pass(ctl.mode_sel, f_mode);
    ctx_eq     = f_ctx == val;
    ctx_ok     = ctl.en && (ctl.kind == KIND_CTX) && ctx_eq;
    case (ctl.kind)
      KIND_ADDR:        raw = addr_match;
      KIND_ADDR_LINKED: raw = addr_match && link_ctx_ok;
      KIND_CTX:         raw = ctx_eq;
      KIND_ADDR_INV:    raw = !addr_match;
      default:          raw = 1'b0;
    endcase
    hit = ctl.en && mode_ok && raw;
  end

  // R8: a linked pair never hits unless its partner matched the context
  a_r8_link_needs_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl.kind == KIND_ADDR_LINKED) |-> link_ctx_ok);

  // R7: a context pair only hits on an exact context ID
  a_r7_ctx_needs_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl.kind == KIND_CTX) |-> (f_ctx == val));

endmodule

// File: rtl/ibrk_evt.sv
module ibrk_evt #(
  parameter int unsigned NUM_PAIRS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 f_valid,
  input  logic [NUM_PAIRS-1:0] raw_hits,
  output logic                 ev,
  output logic [NUM_PAIRS-1:0] hits
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev   <= 1'b0;
      hits <= '0;
    end else begin
      ev   <= f_valid && (|raw_hits);
      hits <= f_valid ? raw_hits : '0;
    end
  end

  a_r10_event_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ev |-> $past(f_valid));

  a_r10_hits_imply_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |-> ev);

endmodule

// File: rtl/ibrk_bank.sv
module ibrk_bank
  import ibrk_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  localparam int unsigned IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_ctl,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 fetch_valid,
  input  logic [31:0]          fetch_addr,
  input  logic                 fetch_word,
  input  logic [1:0]           fetch_mode,
  input  logic [31:0]          fetch_ctx,
  output logic                 bp_event,
  output logic [NUM_PAIRS-1:0] bp_hits
);

  logic [NUM_PAIRS-1:0][31:0] val_w;
  bctl_t [NUM_PAIRS-1:0]      ctl_w;
  logic [NUM_PAIRS-1:0]       ctx_ok_w;
  logic [NUM_PAIRS-1:0]       link_ok_w;
  logic [NUM_PAIRS-1:0]       raw_hits_w;

  ibrk_regs #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .wr_ctl(reg_ctl),
    .idx   (reg_idx),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .val_o (val_w),
    .ctl_o (ctl_w)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    always_comb begin
      if (32'(ctl_w[g].link) < NUM_PAIRS) link_ok_w[g] = ctx_ok_w[ctl_w[g].link[IDX_W-1:0]];
      else                                 link_ok_w[g] = 1'b0;
    end

    ibrk_cmp u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .val        (val_w[g]),
      .ctl        (ctl_w[g]),
      .f_addr     (fetch_addr),
      .f_word     (fetch_word),
      .f_mode     (fetch_mode),
      .f_ctx      (fetch_ctx),
      .link_ctx_ok(link_ok_w[g]),
      .hit        (raw_hits_w[g]),
      .ctx_ok     (ctx_ok_w[g])
    );

    // R9: a reported hit needs the pair enabled at the fetch
    a_r9_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hits[g] |-> $past(ctl_w[g].en));
  end

  ibrk_evt #(.NUM_PAIRS(NUM_PAIRS)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .f_valid (fetch_valid),
    .raw_hits(raw_hits_w),
    .ev      (bp_event),
    .hits    (bp_hits)
  );

endmodule

// File: tb/test_ibrk_bank.sv
module test_ibrk_bank;

  localparam int unsigned N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_ctl = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_word = 1'b0;
  logic [1:0]  fetch_mode = '0;
  logic [31:0] fetch_ctx = '0;
  logic        bp_event;
  logic [N-1:0] bp_hits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ibrk_bank #(.NUM_PAIRS(N)) i_ibrk_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ctl(reg_ctl), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_word(fetch_word), .fetch_mode(fetch_mode),
    .fetch_ctx(fetch_ctx), .bp_event(bp_event), .bp_hits(bp_hits)
  );

  // Control word built from the bit positions given in the requirements.
  function automatic logic [31:0] cw(input logic en, input logic [1:0] msel, input logic [3:0] bas,
                                     input logic [3:0] lnk, input logic [2:0] kind, input logic [4:0] msk);
    return {3'b0, msk, 1'b0, kind, lnk, 7'b0, bas, 2'b0, msel, en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel_ctl, input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ctl = sel_ctl; reg_idx = 2'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic sel_ctl, input int idx, input logic [31:0] exp);
    @(negedge clk);
    reg_ctl = sel_ctl; reg_idx = 2'(idx);
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      wr(1'b1, i, 32'd0);
      wr(1'b0, i, 32'd0);
    end
  endtask

  // One fetch, then check the registered outputs one edge later.
  task automatic fetch_chk(input string req, input logic vld, input logic [31:0] a, input logic w,
                           input logic [1:0] m, input logic [31:0] c, input logic [N-1:0] exp);
    @(negedge clk);
    fetch_valid = vld; fetch_addr = a; fetch_word = w; fetch_mode = m; fetch_ctx = c;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(req, 32'(bp_hits), 32'(exp));
    check(req, 32'(bp_event), 32'(|exp));
  endtask

  task automatic t_reset();
    check("R1 event", 32'(bp_event), 0);
    check("R1 hits", 32'(bp_hits), 0);
    for (int i = 0; i < N; i++) begin
      rd_check("R1 ctl", 1'b1, i, 0);
      rd_check("R1 val", 1'b0, i, 0);
    end
    fetch_chk("R1 no hit after reset", 1'b1, 32'h0, 1'b1, 2'b00, 32'h0, 4'b0000);
  endtask

  task automatic t_regs();
    wr(1'b0, 1, 32'h1234_5678);
    rd_check("R2 value readback", 1'b0, 1, 32'h1234_5678);
    wr(1'b1, 1, 32'hFFFF_FFFE);
    rd_check("R2 ctl reserved bits read 0", 1'b1, 1, 32'hFFFF_FFE6);
    wr(1'b1, 1, 32'h0000_0018);
    rd_check("R2 reserved-only write", 1'b1, 1, 32'h0);
    clear_all();
  endtask

  task automatic t_lanes();
    wr(1'b0, 0, 32'h0000_1000);
    wr(1'b1, 0, cw(1, 2'b11, 4'b0011, 0, 3'b000, 0));
    fetch_chk("R4 lo half hits", 1, 32'h1000, 0, 2'b00, 0, 4'b0001);
    fetch_chk("R4 hi half misses lo select", 1, 32'h1002, 0, 2'b00, 0, 4'b0000);
    fetch_chk("R4 word overlaps lo select", 1, 32'h1000, 1, 2'b00, 0, 4'b0001);
    fetch_chk("R10 no fetch no event", 0, 32'h1000, 1, 2'b00, 0, 4'b0000);
    wr(1'b1, 0, cw(1, 2'b11, 4'b1100, 0, 3'b000, 0));
    fetch_chk("R4 hi half hits hi select", 1, 32'h1002, 0, 2'b00, 0, 4'b0001);
    fetch_chk("R4 lo half misses hi select", 1, 32'h1000, 0, 2'b00, 0, 4'b0000);
    wr(1'b1, 0, cw(1, 2'b11, 4'b0000, 0, 3'b000, 0));
    fetch_chk("R4 select 0000 never hits", 1, 32'h1000, 1, 2'b00, 0, 4'b0000);
    wr(1'b1, 0, cw(1, 2'b11, 4'b1111, 0, 3'b000, 0));
    fetch_chk("R3 next word misses", 1, 32'h1004, 1, 2'b00, 0, 4'b0000);
    fetch_chk("R3 upper bit differs", 1, 32'h8000_1000, 1, 2'b00, 0, 4'b0000);
    clear_all();
  endtask

  task automatic t_mask();
    wr(1'b0, 0, 32'h2000_1200);
    wr(1'b1, 0, cw(1, 2'b11, 4'b1111, 0, 3'b000, 5'd8));
    fetch_chk("R3 masked low bits hit", 1, 32'h2000_12FC, 1, 2'b00, 0, 4'b0001);
    fetch_chk("R3 bit 8 still compared", 1, 32'h2000_1300, 1, 2'b00, 0, 4'b0000);
    clear_all();
  endtask

  task automatic t_inverse();
    wr(1'b0, 0, 32'h0000_1000);
    wr(1'b1, 0, cw(1, 2'b11, 4'b1111, 0, 3'b100, 0));
    fetch_chk("R5 inverse misses own word", 1, 32'h1000, 1, 2'b00, 0, 4'b0000);
    fetch_chk("R5 inverse hits other word", 1, 32'h1004, 1, 2'b00, 0, 4'b0001);
    wr(1'b1, 0, cw(1, 2'b11, 4'b0000, 0, 3'b100, 0));
    fetch_chk("R5 inverse with 0000 hits all", 1, 32'h1000, 1, 2'b00, 0, 4'b0001);
    wr(1'b1, 0, cw(1, 2'b11, 4'b0011, 0, 3'b100, 0));
    fetch_chk("R5 inverse hi half hits", 1, 32'h1002, 0, 2'b00, 0, 4'b0001);
    fetch_chk("R5 inverse lo half misses", 1, 32'h1000, 0, 2'b00, 0, 4'b0000);
    clear_all();
  endtask

  task automatic t_mode();
    wr(1'b0, 0, 32'h0000_1000);
    wr(1'b1, 0, cw(1, 2'b00, 4'b1111, 0, 3'b000, 0));
    fetch_chk("R6 filter00 user", 1, 32'h1000, 1, 2'b00, 0, 4'b0001);
    fetch_chk("R6 filter00 supervisor", 1, 32'h1000, 1, 2'b01, 0, 4'b0001);
    fetch_chk("R6 filter00 system", 1, 32'h1000, 1, 2'b10, 0, 4'b0001);
    fetch_chk("R6 filter00 other priv", 1, 32'h1000, 1, 2'b11, 0, 4'b0000);
    wr(1'b1, 0, cw(1, 2'b01, 4'b1111, 0, 3'b000, 0));
    fetch_chk("R6 filter01 user", 1, 32'h1000, 1, 2'b00, 0, 4'b0000);
    fetch_chk("R6 filter01 other priv", 1, 32'h1000, 1, 2'b11, 0, 4'b0001);
    wr(1'b1, 0, cw(1, 2'b10, 4'b1111, 0, 3'b000, 0));
    fetch_chk("R6 filter10 user", 1, 32'h1000, 1, 2'b00, 0, 4'b0001);
    fetch_chk("R6 filter10 supervisor", 1, 32'h1000, 1, 2'b01, 0, 4'b0000);
    clear_all();
  endtask

  task automatic t_ctx();
    wr(1'b0, 2, 32'hCAFE_0001);
    wr(1'b1, 2, cw(1, 2'b11, 4'b1111, 0, 3'b010, 0));
    fetch_chk("R7 ctx equal hits", 1, 32'h5555_0002, 0, 2'b01, 32'hCAFE_0001, 4'b0100);
    fetch_chk("R7 ctx bit0 differs", 1, 32'hCAFE_0000, 1, 2'b01, 32'hCAFE_0000, 4'b0000);
  endtask

  task automatic t_link();
    wr(1'b0, 0, 32'h0000_1000);
    wr(1'b1, 0, cw(1, 2'b11, 4'b1111, 4'd2, 3'b001, 0));
    fetch_chk("R8 addr and ctx", 1, 32'h1000, 1, 2'b00, 32'hCAFE_0001, 4'b0101);
    fetch_chk("R8 ctx wrong", 1, 32'h1000, 1, 2'b00, 32'hCAFE_0003, 4'b0000);
    fetch_chk("R8 addr wrong", 1, 32'h1004, 1, 2'b00, 32'hCAFE_0001, 4'b0100);
    wr(1'b1, 0, cw(1, 2'b11, 4'b1111, 4'd3, 3'b001, 0));
    fetch_chk("R8 link to disabled pair", 1, 32'h1000, 1, 2'b00, 32'hCAFE_0001, 4'b0100);
    wr(1'b1, 0, cw(1, 2'b11, 4'b1111, 4'd5, 3'b001, 0));
    fetch_chk("R8 link index out of range", 1, 32'h1000, 1, 2'b00, 32'hCAFE_0001, 4'b0100);
    wr(1'b1, 0, cw(1, 2'b10, 4'b1111, 4'd2, 3'b001, 0));
    fetch_chk("R8 own mode filter", 1, 32'h1000, 1, 2'b01, 32'hCAFE_0001, 4'b0100);
    clear_all();
  endtask

  task automatic t_enable();
    wr(1'b0, 1, 32'h0000_1000);
    wr(1'b1, 1, cw(0, 2'b11, 4'b1111, 0, 3'b000, 0));
    fetch_chk("R9 disabled pair", 1, 32'h1000, 1, 2'b00, 0, 4'b0000);
    wr(1'b1, 1, cw(1, 2'b11, 4'b0000, 0, 3'b011, 0));
    fetch_chk("R9 kind 011", 1, 32'h1000, 1, 2'b00, 0, 4'b0000);
    wr(1'b1, 1, cw(1, 2'b11, 4'b1111, 0, 3'b111, 0));
    fetch_chk("R9 kind 111", 1, 32'h1004, 1, 2'b00, 0, 4'b0000);
    wr(1'b1, 1, cw(1, 2'b11, 4'b1111, 0, 3'b000, 0));
    fetch_chk("R9 enabled pair hits", 1, 32'h1000, 1, 2'b00, 0, 4'b0010);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_lanes();
    t_mask();
    t_inverse();
    t_mode();
    t_ctx();
    t_link();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule